// File: doc/BRIEF.md
# Register-Operand ALU with Per-Unit Operand Isolation

This block is a small execution datapath. It holds four general registers. Each cycle it reads two of them through 2-bit source fields and runs one of four operations picked by a 2-bit opcode. The outcome can be written back to any register on the next rising clock edge. The result and the two arithmetic flags are also visible combinationally on output ports in the same cycle.

Every functional unit (bitwise AND, bitwise OR, adder, subtractor) is permanently present and evaluates in parallel. One decoder turns the opcode into one-hot select terms, and each term is computed once and shared. The operands of a unit are forced to zero unless that unit's term is high, so idle units see constant zero inputs and do not switch. The same term masks the unit's output before an AND-OR network merges the four results into one word. A per-unit activity vector brings the operand isolation out to the ports.

Registers can be seeded from outside through a load port. That port takes priority over the ALU write-back. An active-low synchronous reset clears all four registers.

Top module: `galu_core`

## Requirements
- R1: Opcode 2'b00 gives the bitwise AND of the two operands, 2'b01 the bitwise OR, 2'b10 their sum modulo 2^W, and 2'b11 the difference left minus right modulo 2^W. All of these act on the full word.
- R2: The left operand is register n when `src_a` equals n, and the right operand is register n when `src_b` equals n. Bit 0 of each field is the low-order select bit.
- R3: `unit_act` bit 0 belongs to the AND unit, bit 1 to OR, bit 2 to the adder and bit 3 to the subtractor. A bit is high only when its unit is selected and at least one of the two operands has a nonzero bit. Every unselected unit's bit stays low.
- R4: `carry_out` equals the carry out of the top bit of the addition when the opcode is 2'b10, and is low for every other opcode.
- R5: `borrow_out` is high when the opcode is 2'b11 and the left operand is less than the right one as unsigned values. It is low otherwise.
- R6: On a rising edge with `wr_en` high and `ld_en` low, `result` is written into register `dst`. With `ld_en` high, `ld_data` is written into register `dst` whatever the state of `wr_en`.
- R7: On a rising edge with both `wr_en` and `ld_en` low, no register changes.
- R8: A rising edge with `rst_n` low clears all four registers to zero.
- R9: `result`, `carry_out`, `borrow_out` and `unit_act` follow the register contents, source fields and opcode combinationally within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write `result` back into register `dst` |
| ld_en | input | 1 | Write `ld_data` into register `dst`; takes priority over `wr_en` |
| ld_data | input | W | Externally supplied register value |
| opcode | input | 2 | Operation select: 00 AND, 01 OR, 10 add, 11 subtract |
| src_a | input | 2 | Left operand register select |
| src_b | input | 2 | Right operand register select |
| dst | input | 2 | Destination register select |
| result | output | W | Selected operation result |
| carry_out | output | 1 | Carry out of the addition |
| borrow_out | output | 1 | Borrow out of the subtraction |
| unit_act | output | 4 | Per-unit nonzero-operand indicator |

## Verification
The clocked checks assume that the opcode, source, destination and enable inputs are driven to known values on every clock edge once reset is released. Under that assumption the decoder always yields exactly one select term, and the reference sums computed from the register read ports are meaningful. The stimulus holds every input at a defined level from time zero. It changes inputs only on falling edges, so each sampled edge sees settled operands. Register contents are loaded through the load port before any arithmetic vectors are applied, which keeps the read ports free of unknowns.

// File: rtl/galu_pkg.sv
// Package: shared opcode encoding and structural counts for the gated ALU.
// Assumes a fixed four-register file addressed by 2-bit fields.
package galu_pkg;
    localparam int NUM_REGS  = 4;
    localparam int SEL_W     = 2;
    localparam int NUM_UNITS = 4;

    typedef enum logic [1:0] {
        OP_AND = 2'b00,
        OP_OR  = 2'b01,
        OP_ADD = 2'b10,
        OP_SUB = 2'b11
    } alu_op_e;
endpackage

// File: rtl/galu_opdec.sv
// Module: one-hot opcode decoder. Each output term is computed once and
// shared by every gate that needs to know whether its unit is selected.
// Assumes the opcode is a defined 2-bit value.
module galu_opdec
    import galu_pkg::*;
(
    input  logic [SEL_W-1:0]     op,
    output logic [NUM_UNITS-1:0] op_hot
);
    // Each select term is the product of the opcode bits in true or complement form.
    for (genvar k = 0; k < NUM_UNITS; k++) begin : g_term
        localparam logic [SEL_W-1:0] CODE = SEL_W'(k);
        logic [SEL_W-1:0] lit;
        for (genvar b = 0; b < SEL_W; b++) begin : g_lit
            assign lit[b] = CODE[b] ? op[b] : ~op[b];
        end
        assign op_hot[k] = &lit;
    end
endmodule

// File: rtl/galu_regfile.sv
// Module: four-entry register file with two AND-OR read networks and one
// write port. Synchronous active-low reset clears every entry.
// Assumes at most one write per clock edge.
module galu_regfile
    import galu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] wsel,
    input  logic [W-1:0]     wdata,
    input  logic [SEL_W-1:0] rsel_a,
    input  logic [SEL_W-1:0] rsel_b,
    output logic [W-1:0]     rdata_a,
    output logic [W-1:0]     rdata_b
);
    logic [W-1:0]          regs [NUM_REGS];
    logic [NUM_REGS*W-1:0] regs_flat;

    // Storage update: reset clears, otherwise the addressed entry takes wdata.
    always_ff @(posedge clk) begin
        for (int k = 0; k < NUM_REGS; k++) begin
            if (!rst_n)
                regs[k] <= '0;
            else if (we && (wsel == SEL_W'(k)))
                regs[k] <= wdata;
        end
    end

    // Read networks: OR of each entry masked by its decoded select term.
    always_comb begin
        rdata_a = '0;
        rdata_b = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            rdata_a = rdata_a | (regs[k] & {W{rsel_a == SEL_W'(k)}});
            rdata_b = rdata_b | (regs[k] & {W{rsel_b == SEL_W'(k)}});
        end
    end

    // Flattened copy of the storage for the stability check.
    always_comb begin
        for (int k = 0; k < NUM_REGS; k++)
            regs_flat[k*W +: W] = regs[k];
    end

    // R6: a write lands in the addressed entry.
    a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (regs[$past(wsel)] == $past(wdata)));

    // R7: without a write the storage holds.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(regs_flat));
endmodule

// File: rtl/galu_ripple.sv
// Module: ripple-carry adder. Bit 0 sums the operand bits with the carry in,
// and each higher bit adds in the carry produced by the bits below it.
// Assumes nothing about its inputs; all zero inputs give a quiet output.
module galu_ripple #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] c;
    assign c[0] = cin;

    // One full-adder cell per bit position.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i] = a[i] ^ b[i] ^ c[i];
        assign c[i+1] = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
    end

    assign cout = c[W];
endmodule

// File: rtl/galu_core.sv
// Module: top of the gated ALU. Reads two registers, feeds them only to the
// unit named by the opcode, merges masked unit outputs through an AND-OR
// network, and writes back either the result or an external load value.
// Assumes all control inputs are driven to known values out of reset.
module galu_core
    import galu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 ld_en,
    input  logic [W-1:0]         ld_data,
    input  logic [1:0]           opcode,
    input  logic [1:0]           src_a,
    input  logic [1:0]           src_b,
    input  logic [1:0]           dst,
    output logic [W-1:0]         result,
    output logic                 carry_out,
    output logic                 borrow_out,
    output logic [NUM_UNITS-1:0] unit_act
);
    localparam int U_AND = int'(OP_AND);
    localparam int U_OR  = int'(OP_OR);
    localparam int U_ADD = int'(OP_ADD);
    localparam int U_SUB = int'(OP_SUB);

    logic [W-1:0]         rd_a, rd_b;
    logic [NUM_UNITS-1:0] op_hot;
    logic [W-1:0]         umask [NUM_UNITS];
    logic [W-1:0]         ga    [NUM_UNITS];
    logic [W-1:0]         gb    [NUM_UNITS];
    logic [W-1:0]         ures  [NUM_UNITS];
    logic [W-1:0]         add_sum, sub_sum, sub_nb;
    logic                 add_co, sub_co;
    logic                 rf_we;
    logic [W-1:0]         rf_wdata;

    galu_regfile #(.W(W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .wsel    (dst),
        .wdata   (rf_wdata),
        .rsel_a  (src_a),
        .rsel_b  (src_b),
        .rdata_a (rd_a),
        .rdata_b (rd_b)
    );

    galu_opdec u_dec (
        .op     (opcode),
        .op_hot (op_hot)
    );

    // Operand isolation: every unit gets its inputs ANDed with its own select term.
    for (genvar k = 0; k < NUM_UNITS; k++) begin : g_gate
        assign umask[k]    = {W{op_hot[k]}};
        assign ga[k]       = rd_a & umask[k];
        assign gb[k]       = rd_b & umask[k];
        assign unit_act[k] = |(ga[k] | gb[k]);
    end

    // Logic units act bitwise on the whole word and are masked again at the output.
    assign ures[U_AND] = (ga[U_AND] & gb[U_AND]) & umask[U_AND];
    assign ures[U_OR]  = (ga[U_OR]  | gb[U_OR])  & umask[U_OR];

    galu_ripple #(.W(W)) u_add (
        .a    (ga[U_ADD]),
        .b    (gb[U_ADD]),
        .cin  (1'b0),
        .sum  (add_sum),
        .cout (add_co)
    );
    assign ures[U_ADD] = add_sum & umask[U_ADD];

    // Subtraction as left plus inverted right plus one; inversion kept behind the gate.
    assign sub_nb = ~gb[U_SUB] & umask[U_SUB];
    galu_ripple #(.W(W)) u_sub (
        .a    (ga[U_SUB]),
        .b    (sub_nb),
        .cin  (op_hot[U_SUB]),
        .sum  (sub_sum),
        .cout (sub_co)
    );
    assign ures[U_SUB] = sub_sum & umask[U_SUB];

    // Result selection: OR of all masked unit outputs.
    always_comb begin
        result = '0;
        for (int k = 0; k < NUM_UNITS; k++)
            result = result | ures[k];
    end

    assign carry_out  = add_co & op_hot[U_ADD];
    assign borrow_out = ~sub_co & op_hot[U_SUB];

    // Write-back source: external load wins over the ALU result.
    assign rf_we    = wr_en | ld_en;
    assign rf_wdata = ld_en ? ld_data : result;

    // R3: at most one unit sees nonzero operands.
    a_r3_single_active: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(unit_act));

    // R3: an active unit is always the one the opcode names.
    a_r3_active_is_selected: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_act != '0) |-> unit_act[opcode]);

    // R4: addition matches a wide reference sum of the read ports.
    a_r4_add_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_ADD) |-> ({carry_out, result} == ({1'b0, rd_a} + {1'b0, rd_b})));

    // R5: subtraction result and borrow match an unsigned compare.
    a_r5_sub_borrow: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_SUB) |-> ((borrow_out == (rd_a < rd_b)) && (result == W'(rd_a - rd_b))));

    // R1: logic operations raise neither flag.
    a_r1_logic_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode[1] == 1'b0) |-> (!carry_out && !borrow_out));
endmodule

// File: tb/galu_core_tb.sv
// Bench for galu_core: vector table walked by one loop, then directed tests.
module galu_core_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic         ld_en = 1'b0;
    logic [W-1:0] ld_data = '0;
    logic [1:0]   opcode = 2'b00;
    logic [1:0]   src_a = 2'b00;
    logic [1:0]   src_b = 2'b00;
    logic [1:0]   dst = 2'b00;
    logic [W-1:0] result;
    logic         carry_out;
    logic         borrow_out;
    logic [3:0]   unit_act;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    galu_core #(.W(W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .ld_en      (ld_en),
        .ld_data    (ld_data),
        .opcode     (opcode),
        .src_a      (src_a),
        .src_b      (src_b),
        .dst        (dst),
        .result     (result),
        .carry_out  (carry_out),
        .borrow_out (borrow_out),
        .unit_act   (unit_act)
    );

    typedef struct packed {
        logic [1:0] op;
        logic [1:0] sa;
        logic [1:0] sb;
        logic [7:0] res;
        logic       c;
        logic       bw;
    } vec_t;

    // Registers hold r0=3C r1=A5 r2=FF r3=01 when this table runs.
    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 2'd0, 2'd1, 8'h24, 1'b0, 1'b0},
        '{2'b01, 2'd0, 2'd1, 8'hBD, 1'b0, 1'b0},
        '{2'b10, 2'd0, 2'd1, 8'hE1, 1'b0, 1'b0},
        '{2'b10, 2'd2, 2'd3, 8'h00, 1'b1, 1'b0},
        '{2'b11, 2'd0, 2'd1, 8'h97, 1'b0, 1'b1},
        '{2'b11, 2'd1, 2'd0, 8'h69, 1'b0, 1'b0},
        '{2'b11, 2'd2, 2'd2, 8'h00, 1'b0, 1'b0},
        '{2'b00, 2'd2, 2'd1, 8'hA5, 1'b0, 1'b0},
        '{2'b01, 2'd3, 2'd0, 8'h3D, 1'b0, 1'b0},
        '{2'b10, 2'd2, 2'd2, 8'hFE, 1'b1, 1'b0},
        '{2'b11, 2'd3, 2'd2, 8'h02, 1'b0, 1'b1}
    };

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    // Apply an operation with no write and sample in the low clock phase.
    task automatic apply(input logic [1:0] op, input logic [1:0] sa, input logic [1:0] sb);
        @(negedge clk);
        wr_en = 1'b0; ld_en = 1'b0;
        opcode = op; src_a = sa; src_b = sb;
        #5;
    endtask

    // Read a register through the OR path with both sources on it.
    task automatic read_reg(input logic [1:0] r, input string tag, input logic [7:0] exp);
        apply(2'b01, r, r);
        check(tag, 32'(result), 32'(exp));
    endtask

    task automatic load(input logic [1:0] d, input logic [7:0] v);
        @(negedge clk);
        ld_en = 1'b1; dst = d; ld_data = v;
        @(posedge clk);
        #1 ld_en = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R8: reset state of every register.
        for (int r = 0; r < 4; r++) read_reg(2'(r), "R8 reset clears register", 8'h00);

        // R3: zero operands leave every activity bit low.
        apply(2'b10, 2'd0, 2'd1);
        check("R3 zero operands no activity", 32'(unit_act), 32'h0);

        // R6: load port fills the registers.
        load(2'd0, 8'h3C); load(2'd1, 8'hA5); load(2'd2, 8'hFF); load(2'd3, 8'h01);
        read_reg(2'd0, "R6 R2 load r0", 8'h3C);
        read_reg(2'd3, "R6 R2 load r3", 8'h01);

        // R1 R2 R3 R4 R5 R9: table walk.
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].op, VECS[i].sa, VECS[i].sb);
            check($sformatf("R1 R2 R9 result vec %0d", i), 32'(result), 32'(VECS[i].res));
            check($sformatf("R4 carry vec %0d", i), 32'(carry_out), 32'(VECS[i].c));
            check($sformatf("R5 borrow vec %0d", i), 32'(borrow_out), 32'(VECS[i].bw));
            check($sformatf("R3 activity vec %0d", i), 32'(unit_act), 32'(4'b0001 << VECS[i].op));
        end

        // R6: ALU write-back of add r0+r1 into r3.
        @(negedge clk);
        opcode = 2'b10; src_a = 2'd0; src_b = 2'd1; dst = 2'd3; wr_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
        read_reg(2'd3, "R6 write-back", 8'hE1);

        // R7: no enable, no change.
        @(negedge clk);
        opcode = 2'b11; src_a = 2'd1; src_b = 2'd0; dst = 2'd2;
        @(posedge clk);
        read_reg(2'd2, "R7 hold without enable", 8'hFF);

        // R6: load wins over write-back.
        @(negedge clk);
        opcode = 2'b01; src_a = 2'd0; src_b = 2'd1; dst = 2'd1;
        wr_en = 1'b1; ld_en = 1'b1; ld_data = 8'h5A;
        @(posedge clk);
        #1 begin wr_en = 1'b0; ld_en = 1'b0; end
        read_reg(2'd1, "R6 load priority", 8'h5A);

        // R8: reset again clears loaded contents.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1 rst_n = 1'b1;
        for (int r = 0; r < 4; r++) read_reg(2'(r), "R8 second reset", 8'h00);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule